// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit executes the single-bit Boolean instructions of a small 8-bit CPU core. The core presents an instruction that has already been decoded: an operation code, an operand-space code, a bit index and a resolved operand address. It raises `start_i` for one clock. The unit reads the operand byte where it has to, through a memory port that can stall. It then folds the chosen bit into the carry flag, or forces that bit to 1 or 0 and writes the byte back. In the last clock of the instruction it pulses `done_o`. In that same clock it presents any new accumulator or flag-word value together with its write enable.

Each instruction takes an exact number of clocks. That number depends on the operation, on the operand space and on whether the address falls inside the fast internal RAM window. Every clock in which the memory port holds ready low adds one clock. The core holds `acc_i` and `psw_i` steady while it waits. The unit also latches both values when it accepts an instruction.

Top module: `bitop_unit`

## Requirements
- R1: The carry-only operations (op codes 5 set-carry, 6 clear-carry, 7 complement-carry) each take 2 clocks and make no memory access. The carry is flag-word bit 0, and the new flag word has bit 0 equal to 1, 0 or the inverse of the old carry, respectively.
- R2: The combine operations (op 0 AND, op 1 OR, op 2 XOR) write old carry AND, OR or XOR the selected bit into flag-word bit 0, with `psw_we_o` high. The operand is never written: no memory write and no accumulator write. A memory operand (space code 2, 3 or 4) is read exactly once.
- R3: Set (op 3) and clear (op 4) force bit `bit_i` of the operand to 1 or 0 and keep the carry unchanged. A memory operand is read once and written once, and the other seven bits are written back as they were read.
- R4: With an accumulator operand (space code 0), the combine, set and clear operations take 4 clocks. Set and clear write the new accumulator through `acc_o` with `acc_we_o`.
- R5: With a flag-word operand (space 1), combine takes 7 clocks and set or clear takes 6. With a special-register operand (space 3), combine takes 7 clocks and set or clear takes 8.
- R6: With a short direct operand (space 2), combine takes 6 clocks inside the fast window and 7 outside it. Set or clear takes 4 inside and 6 outside. The window runs from FAST_LO to FAST_HI, by default 0xFB00 to 0xFEFF.
- R7: With an indirect operand (space 4), every operation takes 6 clocks inside the fast window. Outside it, combine takes 7 plus the read waits and set or clear takes 8 plus the read waits plus the write waits.
- R8: Each clock of a read or write transfer in which `mem_rdy_i` is low adds one clock to the instruction. During that clock the request, the direction and the address stay unchanged.
- R9: `done_o` is high for exactly one clock per accepted instruction, in its last clock. A `start_i` raised while an instruction is still executing is ignored.
- R10: For every operand other than the flag word, the presented flag word differs from the old one in bit 0 at most. Zero, auxiliary carry and the other bits keep their values.
- R11: While reset is asserted, `done_o`, `mem_req_o`, `acc_we_o` and `psw_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| op_i | input | 3 | Operation code |
| space_i | input | 3 | Operand space code |
| bit_i | input | 3 | Bit index 0..7 |
| addr_i | input | AW | Resolved operand address |
| acc_i | input | 8 | Current accumulator |
| psw_i | input | 8 | Current flag word (bit 0 = carry) |
| done_o | output | 1 | Last clock of the instruction |
| acc_o | output | 8 | New accumulator value |
| acc_we_o | output | 1 | Accumulator write enable, with done |
| psw_o | output | 8 | New flag word value |
| psw_we_o | output | 1 | Flag word write enable, with done |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | AW | Transfer address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| mem_rdy_i | input | 1 | Transfer completes this clock |

## Verification
The hardest case to reach is a set or clear on an external indirect operand where ready is held low in both the read and the write transfer. In that case the write has to wait for the stalled read, and the count must pause twice without losing the byte it read. The bench's memory model counts down a separate wait budget for each transfer direction and uses it to hold ready low. One directed case also keeps `start_i` high with a different operation for the whole of such a stalled instruction. The bench then confirms that the first operation alone completes, with a single done pulse.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DW    = 8;
  localparam int BW    = 3;
  localparam int LAT_W = 4;
  localparam int CY_POS = 0;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_SET  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SETC = 3'd5,
    OP_CLRC = 3'd6,
    OP_NOTC = 3'd7
  } bop_e;

  typedef enum logic [2:0] {
    SP_ACC  = 3'd0,
    SP_PSW  = 3'd1,
    SP_SDIR = 3'd2,
    SP_SFR  = 3'd3,
    SP_IND  = 3'd4
  } bsp_e;

  function automatic logic is_comb(input bop_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_wr(input bop_e op);
    return (op == OP_SET) || (op == OP_CLR);
  endfunction

  function automatic logic is_cy(input bop_e op);
    return (op == OP_SETC) || (op == OP_CLRC) || (op == OP_NOTC);
  endfunction

  function automatic logic is_mem(input bsp_e sp);
    return (sp == SP_SDIR) || (sp == SP_SFR) || (sp == SP_IND);
  endfunction

  // base clocks with ready held high
  function automatic logic [LAT_W-1:0] base_lat(input bop_e op, input bsp_e sp, input logic fast);
    logic [LAT_W-1:0] l;
    if (is_cy(op)) begin
      l = LAT_W'(2);
    end else begin
      unique case (sp)
        SP_PSW:  l = is_comb(op) ? LAT_W'(7) : LAT_W'(6);
        SP_SFR:  l = is_comb(op) ? LAT_W'(7) : LAT_W'(8);
        SP_SDIR: l = is_comb(op) ? (fast ? LAT_W'(6) : LAT_W'(7))
                                 : (fast ? LAT_W'(4) : LAT_W'(6));
        SP_IND:  l = fast ? LAT_W'(6) : (is_comb(op) ? LAT_W'(7) : LAT_W'(8));
        default: l = LAT_W'(4);
      endcase
    end
    return l;
  endfunction
endpackage

// File: rtl/bitop_timer.sv
module bitop_timer
  import bitop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             need_rd_i,
  input  logic             need_wr_i,
  input  logic             rdy_i,
  output logic             busy_o,
  output logic             rd_phase_o,
  output logic             wr_phase_o,
  output logic             done_o
);
  logic [LAT_W-1:0] cnt_q;
  logic busy_q, need_rd_q, need_wr_q, rd_done_q;
  logic stall;

  assign rd_phase_o = busy_q && need_rd_q && !rd_done_q;
  // write sits in the second-to-last clock
  assign wr_phase_o = busy_q && need_wr_q && (cnt_q == LAT_W'(2));
  assign stall      = (rd_phase_o || wr_phase_o) && !rdy_i;
  assign done_o     = busy_q && (cnt_q == LAT_W'(1));
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      need_rd_q <= 1'b0;
      need_wr_q <= 1'b0;
      rd_done_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q    <= 1'b1;
        cnt_q     <= lat_i - LAT_W'(1);
        need_rd_q <= need_rd_i;
        need_wr_q <= need_wr_i;
        rd_done_q <= 1'b0;
      end
    end else begin
      if (rd_phase_o && rdy_i) rd_done_q <= 1'b1;
      if (cnt_q == LAT_W'(1))  busy_q <= 1'b0;
      else if (!stall)         cnt_q  <= cnt_q - LAT_W'(1);
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_read_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_phase_o |-> rd_done_q);

  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/bitop_mem.sv
module bitop_mem
  import bitop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_phase_i,
  input  logic          wr_phase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  input  logic          set_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] byte_o
);
  logic [DW-1:0] byte_q, mask;

  assign mask    = DW'(1) << bit_i;
  assign req_o   = rd_phase_i || wr_phase_i;
  assign we_o    = wr_phase_i;
  assign addr_o  = addr_i;
  assign wdata_o = set_i ? (byte_q | mask) : (byte_q & ~mask);
  assign byte_o  = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 byte_q <= '0;
    else if (rd_phase_i && rdy_i) byte_q <= rdata_i;
  end

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rdy_i) |=> (req_o && $stable(addr_o) && $stable(we_o)));

  a_r3_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> ($countones(wdata_o ^ byte_q) <= 1));
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
(
  input  bop_e          op_i,
  input  bsp_e          sp_i,
  input  logic [BW-1:0] idx_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] psw_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] acc_o,
  output logic          acc_we_o,
  output logic [DW-1:0] psw_o,
  output logic          psw_we_o
);
  logic opb, cy, val;

  always_comb begin
    unique case (sp_i)
      SP_ACC:  opb = acc_i[idx_i];
      SP_PSW:  opb = psw_i[idx_i];
      default: opb = mem_i[idx_i];
    endcase
    cy       = psw_i[CY_POS];
    val      = (op_i == OP_SET);
    acc_o    = acc_i;
    acc_we_o = 1'b0;
    psw_o    = psw_i;
    psw_we_o = 1'b0;
    unique case (op_i)
      OP_AND:  begin psw_o[CY_POS] = cy & opb; psw_we_o = 1'b1; end
      OP_OR:   begin psw_o[CY_POS] = cy | opb; psw_we_o = 1'b1; end
      OP_XOR:  begin psw_o[CY_POS] = cy ^ opb; psw_we_o = 1'b1; end
      OP_SETC: begin psw_o[CY_POS] = 1'b1;     psw_we_o = 1'b1; end
      OP_CLRC: begin psw_o[CY_POS] = 1'b0;     psw_we_o = 1'b1; end
      OP_NOTC: begin psw_o[CY_POS] = ~cy;      psw_we_o = 1'b1; end
      default: begin
        if (sp_i == SP_ACC) begin
          acc_o[idx_i] = val;
          acc_we_o     = 1'b1;
        end else if (sp_i == SP_PSW) begin
          psw_o[idx_i] = val;
          psw_we_o     = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [15:0] FAST_LO = 16'hFB00,
  parameter logic [15:0] FAST_HI = 16'hFEFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [2:0]    space_i,
  input  logic [2:0]    bit_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    acc_i,
  input  logic [7:0]    psw_i,
  output logic          done_o,
  output logic [7:0]    acc_o,
  output logic          acc_we_o,
  output logic [7:0]    psw_o,
  output logic          psw_we_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_rdy_i
);
  bop_e op_in, op_q;
  bsp_e sp_in, sp_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] acc_q, psw_q, mem_byte, acc_res, psw_res;
  logic acc_we_res, psw_we_res;
  logic fast, busy, rd_phase, wr_phase, done, accept;
  logic [LAT_W-1:0] lat;

  assign op_in  = bop_e'(op_i);
  assign sp_in  = bsp_e'(space_i);
  assign fast   = (addr_i >= AW'(FAST_LO)) && (addr_i <= AW'(FAST_HI));
  assign lat    = base_lat(op_in, sp_in, fast);
  assign accept = start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_AND;
      sp_q   <= SP_ACC;
      bit_q  <= '0;
      addr_q <= '0;
      acc_q  <= '0;
      psw_q  <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      sp_q   <= sp_in;
      bit_q  <= bit_i;
      addr_q <= addr_i;
      acc_q  <= acc_i;
      psw_q  <= psw_i;
    end
  end

  bitop_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .lat_i      (lat),
    .need_rd_i  (is_mem(sp_in) && !is_cy(op_in)),
    .need_wr_i  (is_mem(sp_in) && is_wr(op_in)),
    .rdy_i      (mem_rdy_i),
    .busy_o     (busy),
    .rd_phase_o (rd_phase),
    .wr_phase_o (wr_phase),
    .done_o     (done)
  );

  bitop_mem #(.AW(AW)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_phase_i (rd_phase),
    .wr_phase_i (wr_phase),
    .addr_i     (addr_q),
    .bit_i      (bit_q),
    .set_i      (op_q == OP_SET),
    .rdy_i      (mem_rdy_i),
    .rdata_i    (mem_rdata_i),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .byte_o     (mem_byte)
  );

  bitop_alu u_alu (
    .op_i     (op_q),
    .sp_i     (sp_q),
    .idx_i    (bit_q),
    .acc_i    (acc_q),
    .psw_i    (psw_q),
    .mem_i    (mem_byte),
    .acc_o    (acc_res),
    .acc_we_o (acc_we_res),
    .psw_o    (psw_res),
    .psw_we_o (psw_we_res)
  );

  assign done_o   = done;
  assign acc_o    = acc_res;
  assign acc_we_o = done && acc_we_res;
  assign psw_o    = psw_res;
  assign psw_we_o = done && psw_we_res;

  a_r1_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && is_cy(op_q)) |-> !mem_req_o);

  a_r2_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && is_comb(op_q)) |-> !mem_we_o);

  a_r10_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_we_o && sp_q != SP_PSW) |-> (psw_o[7:1] == psw_q[7:1]));

  a_r3_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_we_o && is_wr(op_q) && bit_q != BW'(CY_POS)) |-> (psw_o[CY_POS] == psw_q[CY_POS]));

  a_r11_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!done_o && !mem_req_o && !acc_we_o && !psw_we_o));
endmodule

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [2:0]  op_i, space_i, bit_i;
  logic [15:0] addr_i;
  logic [7:0]  acc_i, psw_i;
  logic        done_o, acc_we_o, psw_we_o, mem_req_o, mem_we_o;
  logic [7:0]  acc_o, psw_o, mem_wdata_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_rdy_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rw_left, ww_left, rd_cnt, wr_cnt;
  logic [7:0] wd_seen;

  always #2.5 clk_i = ~clk_i;

  bitop_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .space_i(space_i), .bit_i(bit_i), .addr_i(addr_i), .acc_i(acc_i),
    .psw_i(psw_i), .done_o(done_o), .acc_o(acc_o), .acc_we_o(acc_we_o),
    .psw_o(psw_o), .psw_we_o(psw_we_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
  );

  // memory model: per-direction wait budgets
  always @(negedge clk_i) begin
    if (mem_req_o && !mem_we_o) begin
      if (rw_left > 0) begin mem_rdy_i = 1'b0; rw_left--; end
      else begin mem_rdy_i = 1'b1; rd_cnt++; end
    end else if (mem_req_o && mem_we_o) begin
      if (ww_left > 0) begin mem_rdy_i = 1'b0; ww_left--; end
      else begin mem_rdy_i = 1'b1; wr_cnt++; wd_seen = mem_wdata_o; end
    end else begin
      mem_rdy_i = 1'b1;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: cycles=%0d expected<%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input int op, input int sp, input bit fast);
    bit comb;
    comb = (op <= 2);
    if (op >= 5) return 2;
    case (sp)
      0: return 4;
      1: return comb ? 7 : 6;
      3: return comb ? 7 : 8;
      2: return comb ? (fast ? 6 : 7) : (fast ? 4 : 6);
      default: return fast ? 6 : (comb ? 7 : 8);
    endcase
  endfunction

  function automatic string lat_tag(input int op, input int sp, input int w);
    if (w != 0) return "R8 latency";
    if (op >= 5) return "R1 latency";
    case (sp)
      0: return "R4 latency";
      1, 3: return "R5 latency";
      2: return "R6 latency";
      default: return "R7 latency";
    endcase
  endfunction

  // {op,space,bit,addr,acc,psw,mem,rd_waits,wr_waits}
  localparam int NV = 21;
  localparam logic [56:0] VEC [NV] = '{
    {3'd5, 3'd0, 3'd0, 16'h0000, 8'h00, 8'h50, 8'h00, 4'd0, 4'd0},
    {3'd6, 3'd0, 3'd0, 16'h0000, 8'h00, 8'h51, 8'h00, 4'd0, 4'd0},
    {3'd7, 3'd0, 3'd0, 16'h0000, 8'h00, 8'hA5, 8'h00, 4'd0, 4'd0},
    {3'd0, 3'd0, 3'd3, 16'h0000, 8'h08, 8'h01, 8'h00, 4'd0, 4'd0},
    {3'd1, 3'd0, 3'd2, 16'h0000, 8'hF0, 8'h50, 8'h00, 4'd0, 4'd0},
    {3'd2, 3'd1, 3'd6, 16'h0000, 8'h00, 8'h41, 8'h00, 4'd0, 4'd0},
    {3'd0, 3'd3, 3'd7, 16'hFF20, 8'h00, 8'h01, 8'h80, 4'd0, 4'd0},
    {3'd1, 3'd2, 3'd1, 16'hFE20, 8'h00, 8'h00, 8'h02, 4'd0, 4'd0},
    {3'd2, 3'd2, 3'd0, 16'hFA80, 8'h00, 8'h01, 8'h01, 4'd0, 4'd0},
    {3'd0, 3'd4, 3'd5, 16'hFC00, 8'h00, 8'h11, 8'h20, 4'd0, 4'd0},
    {3'd1, 3'd4, 3'd4, 16'h8000, 8'h00, 8'h10, 8'h10, 4'd3, 4'd0},
    {3'd3, 3'd0, 3'd7, 16'h0000, 8'h01, 8'h00, 8'h00, 4'd0, 4'd0},
    {3'd4, 3'd1, 3'd6, 16'h0000, 8'h00, 8'h41, 8'h00, 4'd0, 4'd0},
    {3'd3, 3'd3, 3'd2, 16'hFF30, 8'h00, 8'h00, 8'hA0, 4'd0, 4'd0},
    {3'd4, 3'd2, 3'd7, 16'hFD00, 8'h00, 8'h01, 8'hFF, 4'd0, 4'd0},
    {3'd3, 3'd2, 3'd3, 16'hFA00, 8'h00, 8'h00, 8'h00, 4'd0, 4'd0},
    {3'd4, 3'd4, 3'd0, 16'hFB00, 8'h00, 8'h01, 8'h55, 4'd0, 4'd0},
    {3'd3, 3'd4, 3'd6, 16'h9000, 8'h00, 8'h00, 8'h0F, 4'd2, 4'd3},
    {3'd3, 3'd0, 3'd0, 16'h0000, 8'h01, 8'h00, 8'h00, 4'd0, 4'd0},
    {3'd0, 3'd4, 3'd0, 16'h8000, 8'h00, 8'h01, 8'h00, 4'd0, 4'd0},
    {3'd4, 3'd3, 3'd0, 16'hFF40, 8'h00, 8'h00, 8'h01, 4'd1, 4'd1}
  };

  task automatic run(input logic [56:0] v, input bit hold);
    int op, sp, b, rw, ww, lat, got;
    logic [7:0] acc, psw, mem, e_psw, e_acc, e_wd, g_psw, g_acc;
    bit fast, opb, cy, e_psw_we, e_acc_we, g_psw_we, g_acc_we, val;
    int e_wr, e_rd;
    op = int'(v[56:54]); sp = int'(v[53:51]); b = int'(v[50:48]);
    acc = v[31:24]; psw = v[23:16]; mem = v[15:8];
    rw = int'(v[7:4]); ww = int'(v[3:0]);
    fast = (v[47:32] >= 16'hFB00) && (v[47:32] <= 16'hFEFF);
    opb = (sp == 0) ? acc[b] : (sp == 1) ? psw[b] : mem[b];
    cy = psw[0];
    e_psw = psw; e_acc = acc; e_wd = mem; e_psw_we = 0; e_acc_we = 0; e_wr = 0;
    e_rd = (op <= 4 && sp >= 2) ? 1 : 0;
    val = (op == 3);
    case (op)
      0: begin e_psw[0] = cy & opb; e_psw_we = 1; end
      1: begin e_psw[0] = cy | opb; e_psw_we = 1; end
      2: begin e_psw[0] = cy ^ opb; e_psw_we = 1; end
      5: begin e_psw[0] = 1'b1; e_psw_we = 1; end
      6: begin e_psw[0] = 1'b0; e_psw_we = 1; end
      7: begin e_psw[0] = ~cy;  e_psw_we = 1; end
      default: begin
        if (sp == 0) begin e_acc[b] = val; e_acc_we = 1; end
        else if (sp == 1) begin e_psw[b] = val; e_psw_we = 1; end
        else begin e_wd[b] = val; e_wr = 1; end
      end
    endcase
    lat = exp_lat(op, sp, fast) + (e_rd != 0 ? rw : 0) + (e_wr != 0 ? ww : 0);

    @(negedge clk_i);
    rd_cnt = 0; wr_cnt = 0; wd_seen = 8'h00; rw_left = rw; ww_left = ww;
    mem_rdata_i = mem; acc_i = acc; psw_i = psw;
    op_i = v[56:54]; space_i = v[53:51]; bit_i = v[50:48]; addr_i = v[47:32];
    start_i = 1'b1;
    got = 0; g_psw = 0; g_acc = 0; g_psw_we = 0; g_acc_we = 0;
    for (int k = 2; k <= 40; k++) begin
      @(negedge clk_i);
      if (hold) op_i = (op == 3) ? 3'd4 : 3'd3;
      else start_i = 1'b0;
      if (done_o) begin
        got = k; g_psw = psw_o; g_acc = acc_o; g_psw_we = psw_we_o; g_acc_we = acc_we_o;
        start_i = 1'b0;
        break;
      end
    end
    chk(got == lat, lat_tag(op, sp, rw + ww), got, lat);
    @(negedge clk_i);
    chk(!done_o, "R9 done width", done_o, 0);
    chk(g_psw_we == e_psw_we, "R10 psw_we", g_psw_we, e_psw_we);
    if (e_psw_we) chk(g_psw == e_psw, (op <= 2) ? "R2 carry" : (op >= 5) ? "R1 carry" : "R3 psw bit", g_psw, e_psw);
    chk(g_acc_we == e_acc_we, "R4 acc_we", g_acc_we, e_acc_we);
    if (e_acc_we) chk(g_acc == e_acc, "R3 acc bit", g_acc, e_acc);
    chk(rd_cnt == e_rd, (op >= 5) ? "R1 reads" : "R2 reads", rd_cnt, e_rd);
    chk(wr_cnt == e_wr, (op <= 2) ? "R2 writes" : "R3 writes", wr_cnt, e_wr);
    if (e_wr != 0) chk(wd_seen == e_wd, "R3 rmw data", wd_seen, e_wd);
    if (e_psw_we && sp != 1) chk(g_psw[7:1] == psw[7:1], "R10 other flags", g_psw, psw);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; op_i = 0; space_i = 0; bit_i = 0; addr_i = 0;
    acc_i = 0; psw_i = 0; mem_rdata_i = 0; mem_rdy_i = 1'b1;
    rw_left = 0; ww_left = 0; rd_cnt = 0; wr_cnt = 0; wd_seen = 0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!done_o,    "R11 done in reset", done_o, 0);
    chk(!mem_req_o, "R11 req in reset", mem_req_o, 0);
    chk(!acc_we_o,  "R11 acc_we in reset", acc_we_o, 0);
    chk(!psw_we_o,  "R11 psw_we in reset", psw_we_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // R9: start held high with another op during a stalled external set
    run({3'd3, 3'd4, 3'd1, 16'h9000, 8'h00, 8'h00, 8'h00, 4'd1, 4'd1}, 1'b1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i);
      chk(!done_o, "R9 no extra done", done_o, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule